// File: doc/BRIEF.md
# Write Burst Beat Scheduler

This block sits on the controller side of a double-data-rate memory write path. A write command arrives with a two-bit burst-mode setting and a per-command select bit. From these the block decides whether the command is a full eight-beat burst or a four-beat chop. It then places the write data on a beat timeline that starts the write latency (additive plus write CAS latency) after the command. The timeline carries two beats per clock, a rising-half beat and a falling-half beat. A strobe-enable pair frames each burst with a one-clock preamble and a half-clock postamble.

Write data comes in on a valid/ready stream, one pair of beats per transfer. `in_ready` depends only on the block's internal schedule and never on `in_valid`. It is high exactly in the cycle before each scheduled data clock, and a transfer takes place on any rising edge where both are high. The block cannot stall the memory timeline, so back-pressure goes one way only. The source must have the pair ready when asked. If it does not, the block drives zero data for that pair and records a sticky underflow flag. Commands must be at least four clocks apart. Write recovery and write-to-read legality belong to other logic.

Top module: `wr_burst_sched`

## Requirements
- R1: The first data pair of a write commanded on rising edge E0 is on the outputs in the cycle that begins at edge E(WL), where WL = AL + CWL (5 by default). `dqs_en` is 2'b11 in the cycle before it as the preamble.
- R2: With `bl_mode` = 2'b00 every write is a full burst: `beat_mask` = 2'b11 for four consecutive clocks, 8 beats in all.
- R3: With `bl_mode` = 2'b01, `bl_sel` = 1 gives a full burst and `bl_sel` = 0 gives a chop: `beat_mask` = 2'b11 for two clocks and then 2'b00 for the remaining two clocks of the four-clock slot.
- R4: With `bl_mode` = 2'b10 every write is a chop, whatever `bl_sel` is.
- R5: With `bl_mode` = 2'b11 the command schedules nothing, and `err_mode` goes high and stays high until reset.
- R6: Full bursts commanded four clocks apart stream with no idle clock, and `dqs_en` stays 2'b11 across the joint.
- R7: Chops commanded four clocks apart keep the full slot. After the first chop comes one postamble clock (`dqs_en` = 2'b01), then one preamble clock (2'b11), then the second chop's data.
- R8: In the clock after a burst's last valid data clock, `dqs_en` = 2'b01 (bit 0 = first half-clock, bit 1 = second half-clock), unless another burst's preamble or data falls in that clock. In every clock outside preamble, data and postamble it is 2'b00.
- R9: Pairs leave in the order they were accepted. The lower half of `in_pair` goes to `beat_rise` and the upper half to `beat_fall`, which keeps the column order ascending. A full burst takes four transfers and a chop takes two. `in_ready` is high only in the cycle before each data clock.
- R10: If `in_valid` is low at a scheduled transfer, that clock still shows `beat_mask` = 2'b11 but with zero data. `err_underflow` rises and stays high until reset.
- R11: While reset is held, `beat_mask`, `dqs_en`, `in_ready`, `err_mode` and `err_underflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | Write command strobe, one clock |
| bl_mode | input | 2 | Burst-mode setting: 00 full, 01 per-command, 10 chop, 11 reserved |
| bl_sel | input | 1 | Per-command burst select: 1 full, 0 chop (mode 01 only) |
| in_valid | input | 1 | Write data pair valid |
| in_ready | output | 1 | Block takes a pair on this edge |
| in_pair | input | 2*DW | Two beats: low half earlier (rising), high half later (falling) |
| beat_rise | output | DW | Beat for the first half-clock |
| beat_fall | output | DW | Beat for the second half-clock |
| beat_mask | output | 2 | Beat valid per half: bit 0 rise, bit 1 fall |
| dqs_en | output | 2 | Strobe enable per half: bit 0 first, bit 1 second |
| err_mode | output | 1 | Sticky: reserved burst mode seen |
| err_underflow | output | 1 | Sticky: data missing at a scheduled transfer |

## Verification
A command sampled on edge E0 changes `dqs_en` first at edge E(WL-1). That is the preamble, and it is seen in the check WL rows after the command row. Data and mask follow one edge later, so WL+1 rows after the command. The postamble comes one row after the last data row. The sticky flags change at the edge that samples the faulty command or transfer. The bench checks every output on the falling edge after each rising edge. The table's expected columns list each row with these offsets counted from the command row, and the directed underflow test waits the same WL+1 rows before it samples the pair.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int SLOT_CLKS = 4;
  localparam int CHOP_CLKS = SLOT_CLKS / 2;

  typedef enum logic [1:0] {
    BLM_FULL   = 2'b00,
    BLM_SELECT = 2'b01,
    BLM_CHOP   = 2'b10,
    BLM_RSVD   = 2'b11
  } wbs_blmode_e;

  typedef struct packed {
    logic vld;
    logic chop;
  } wbs_slot_t;
endpackage

// File: rtl/wbs_decode.sv
module wbs_decode
  import wbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic [1:0] bl_mode,
  input  logic       bl_sel,
  output wbs_slot_t  slot,
  output logic       err_mode
);
  wbs_blmode_e mode;
  assign mode = wbs_blmode_e'(bl_mode);

  always_comb begin
    slot = '0;
    if (wr_cmd) begin
      unique case (mode)
        BLM_FULL:   begin slot.vld = 1'b1; slot.chop = 1'b0;    end
        BLM_SELECT: begin slot.vld = 1'b1; slot.chop = !bl_sel; end
        BLM_CHOP:   begin slot.vld = 1'b1; slot.chop = 1'b1;    end
        default:    slot = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_mode <= 1'b0;
    else if (wr_cmd && mode == BLM_RSVD) err_mode <= 1'b1;
  end

  assert_rsvd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bl_mode == 2'b11) |=> err_mode);
  assert_mode_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode);
  assert_chop_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bl_mode == 2'b10) |-> (slot.vld && slot.chop));
endmodule

// File: rtl/wbs_delay.sv
module wbs_delay
  import wbs_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  wbs_slot_t slot_in,
  output wbs_slot_t tap_start,
  output wbs_slot_t tap_pre
);
  wbs_slot_t [DEPTH-1:0] stg;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= slot_in;
      end
      assign tap_pre = slot_in;
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[DEPTH-2:0], slot_in};
      end
      assign tap_pre = stg[DEPTH-2];
    end
  endgenerate

  assign tap_start = stg[DEPTH-1];

  assert_pipe_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tap_pre.vld |=> tap_start.vld);
endmodule

// File: rtl/wbs_engine.sv
module wbs_engine
  import wbs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wbs_slot_t     start,
  input  wbs_slot_t     pre,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2*DW-1:0] in_pair,
  output logic [DW-1:0] beat_rise,
  output logic [DW-1:0] beat_fall,
  output logic [1:0]    beat_mask,
  output logic [1:0]    dqs_en,
  output logic          err_underflow
);
  localparam int CW = $clog2(SLOT_CLKS);
  localparam logic [CW-1:0] LAST_FULL = CW'(SLOT_CLKS - 1);
  localparam logic [CW-1:0] LAST_CHOP = CW'(CHOP_CLKS - 1);

  logic          act, chop_q, last_q;
  logic [CW-1:0] cidx;
  logic          n_act, n_chop, n_data, n_last;
  logic [CW-1:0] n_idx;

  always_comb begin
    n_act  = start.vld | (act & (cidx != LAST_FULL));
    n_idx  = start.vld ? '0 : cidx + 1'b1;
    n_chop = start.vld ? start.chop : chop_q;
    n_data = n_act & (!n_chop | (n_idx <= LAST_CHOP));
    n_last = n_data & (n_idx == (n_chop ? LAST_CHOP : LAST_FULL));
  end

  assign in_ready = n_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; chop_q <= 1'b0; last_q <= 1'b0; cidx <= '0;
      beat_rise <= '0; beat_fall <= '0; beat_mask <= '0; dqs_en <= '0;
      err_underflow <= 1'b0;
    end else begin
      act    <= n_act;
      cidx   <= n_idx;
      chop_q <= n_chop;
      last_q <= n_last;
      beat_mask <= {2{n_data}};
      if (n_data && in_valid) begin
        beat_rise <= in_pair[DW-1:0];
        beat_fall <= in_pair[2*DW-1:DW];
      end else begin
        beat_rise <= '0;
        beat_fall <= '0;
      end
      if (n_data || pre.vld) dqs_en <= 2'b11;
      else if (last_q)       dqs_en <= 2'b01;
      else                   dqs_en <= 2'b00;
      if (n_data && !in_valid) err_underflow <= 1'b1;
    end
  end

  assert_slot_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start.vld |-> !(act && cidx != LAST_FULL));
  assert_ready_to_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> beat_mask == 2'b11);
  assert_mask_framed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_mask != 2'b00) |-> dqs_en == 2'b11);
  assert_post_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_en == 2'b01) |-> beat_mask == 2'b00);
  assert_uf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
  assert_uf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (beat_rise == '0 && beat_fall == '0));
endmodule

// File: rtl/wr_burst_sched.sv
module wr_burst_sched
  import wbs_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AL  = 0,
  parameter int CWL = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cmd,
  input  logic [1:0]      bl_mode,
  input  logic            bl_sel,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2*DW-1:0] in_pair,
  output logic [DW-1:0]   beat_rise,
  output logic [DW-1:0]   beat_fall,
  output logic [1:0]      beat_mask,
  output logic [1:0]      dqs_en,
  output logic            err_mode,
  output logic            err_underflow
);
  localparam int WL = AL + CWL;

  wbs_slot_t cmd_slot, tap_start, tap_pre;

  wbs_decode u_decode (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .bl_mode(bl_mode),
    .bl_sel(bl_sel), .slot(cmd_slot), .err_mode(err_mode)
  );

  wbs_delay #(.DEPTH(WL)) u_delay (
    .clk(clk), .rst_n(rst_n), .slot_in(cmd_slot),
    .tap_start(tap_start), .tap_pre(tap_pre)
  );

  wbs_engine #(.DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(tap_start), .pre(tap_pre),
    .in_valid(in_valid), .in_ready(in_ready), .in_pair(in_pair),
    .beat_rise(beat_rise), .beat_fall(beat_fall), .beat_mask(beat_mask),
    .dqs_en(dqs_en), .err_underflow(err_underflow)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (beat_mask == 2'b00 && dqs_en == 2'b00 && !err_mode && !err_underflow));
endmodule

// File: tb/test_wr_burst_sched.sv
`timescale 1ns/1ps
module test_wr_burst_sched;
  localparam int DW = 8;
  localparam int NV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_cmd = 1'b0;
  logic [1:0] bl_mode = 2'b00;
  logic bl_sel = 1'b0;
  logic in_valid = 1'b1;
  logic in_ready;
  logic [2*DW-1:0] in_pair;
  logic [DW-1:0] beat_rise, beat_fall;
  logic [1:0] beat_mask, dqs_en;
  logic err_mode, err_underflow;

  int errors = 0;
  int checks = 0;
  int seq = 0;
  int ready_cnt = 0;
  int exp_seq = 0;

  always #5 clk = ~clk;

  assign in_pair = {DW'(2*seq + 1), DW'(2*seq)};

  always @(posedge clk) begin
    if (in_ready && in_valid) seq <= seq + 1;
    if (in_ready) ready_cnt <= ready_cnt + 1;
  end

  wr_burst_sched #(.DW(DW)) i_wr_burst_sched (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .bl_mode(bl_mode), .bl_sel(bl_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pair(in_pair),
    .beat_rise(beat_rise), .beat_fall(beat_fall), .beat_mask(beat_mask),
    .dqs_en(dqs_en), .err_mode(err_mode), .err_underflow(err_underflow)
  );

  // {cmd, mode[1:0], sel, exp_mask[1:0], exp_dqs[1:0]}, WL = 5
  localparam logic [7:0] VEC [NV] = '{
    8'b1_00_0_00_00, 8'b0_00_0_00_00, 8'b0_00_0_00_00, 8'b0_00_0_00_00,
    8'b1_01_1_00_00, 8'b0_00_0_00_11, 8'b0_00_0_11_11, 8'b0_00_0_11_11,
    8'b0_00_0_11_11, 8'b0_00_0_11_11, 8'b0_00_0_11_11, 8'b0_00_0_11_11,
    8'b1_01_0_11_11, 8'b0_00_0_11_11, 8'b0_00_0_00_01, 8'b0_00_0_00_00,
    8'b1_10_1_00_00, 8'b0_00_0_00_11, 8'b0_00_0_11_11, 8'b0_00_0_11_11,
    8'b0_00_0_00_01, 8'b0_00_0_00_11, 8'b0_00_0_11_11, 8'b0_00_0_11_11,
    8'b1_11_0_00_01, 8'b0_00_0_00_00, 8'b0_00_0_00_00, 8'b0_00_0_00_00,
    8'b1_00_0_00_00, 8'b0_00_0_00_00, 8'b0_00_0_00_00, 8'b0_00_0_00_00,
    8'b0_00_0_00_00, 8'b0_00_0_00_11, 8'b0_00_0_11_11, 8'b0_00_0_11_11,
    8'b0_00_0_11_11, 8'b0_00_0_11_11, 8'b0_00_0_00_01, 8'b0_00_0_00_00
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 mask in reset", 32'(beat_mask), 0);
    check("R11 dqs in reset", 32'(dqs_en), 0);
    check("R11 ready in reset", 32'(in_ready), 0);
    check("R11 flags in reset", 32'({err_mode, err_underflow}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 R6 R7 R8 mask row %0d", i), 32'(beat_mask), 32'(VEC[i][3:2]));
      check($sformatf("R1 R6 R7 R8 dqs row %0d", i), 32'(dqs_en), 32'(VEC[i][1:0]));
      if (VEC[i][3:2] != 2'b00) begin
        check($sformatf("R9 rise row %0d", i), 32'(beat_rise), 32'(DW'(2*exp_seq)));
        check($sformatf("R9 fall row %0d", i), 32'(beat_fall), 32'(DW'(2*exp_seq + 1)));
        exp_seq++;
      end
      if (i == 25) check("R5 reserved mode flagged", 32'(err_mode), 1);
      wr_cmd  = VEC[i][7];
      bl_mode = VEC[i][6:5];
      bl_sel  = VEC[i][4];
    end
    @(negedge clk);
    wr_cmd = 1'b0;
    // 4 + 4 + 2 + 2 + 4 transfers, none for the reserved command
    check("R9 R5 transfer count", 32'(ready_cnt), 16);
    check("R5 flag still set", 32'(err_mode), 1);
    check("R10 no underflow yet", 32'(err_underflow), 0);

    // Underflow: chop with no data on offer
    in_valid = 1'b0;
    wr_cmd = 1'b1; bl_mode = 2'b10; bl_sel = 1'b1;
    @(negedge clk);
    wr_cmd = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 mask kept on underflow", 32'(beat_mask), 3);
    check("R10 zero data on underflow", 32'({beat_rise, beat_fall}), 0);
    check("R10 underflow flag", 32'(err_underflow), 1);
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 underflow sticky", 32'(err_underflow), 1);
    check("R8 idle after chop", 32'(dqs_en), 0);

    // Reset clears sticky flags
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 flags cleared", 32'({err_mode, err_underflow}), 0);
    check("R11 ready low", 32'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule